// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from fourteen maskable vector slots and one software-break input, and presents a single winning vector index to a small 8-bit CPU core. Each maskable slot has a request flag and an enable bit in a small register file. Software can clear flags but cannot set them. A global disable flag masks every maskable slot at once. Three external pins pass through a two-flop synchronizer. An edge detector then raises a request on either a rising or a falling edge, as a per-pin polarity bit selects.

Two slots each serve a pair of event sources. A select bit chooses which member of the pair can raise the request, and events from the other member are dropped. The CPU sees a pending line and a vector index, and answers with a one-cycle acknowledge. In the acknowledge cycle the block clears the flag of the slot the index points at, and it sets the global disable flag. Arbitration is combinational, so the index returned with the acknowledge is always the slot that gets cleared. The break input has no enable bit, ignores the global disable flag and has the lowest priority. A reset leaves nothing pending.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the request flags (address 0, bits 13:0), the enable bits (address 1, bits 13:0) and the control register (address 2, bits 4:0) read 0. The global disable flag (address 3, bit 0) reads 1, and irqPending is 0.
- R2: A maskable slot can win only when its request flag is 1, its enable bit is 1 and the global disable flag is 0.
- R3: A write to address 0 clears every flag whose data bit is 0. A data bit of 1 leaves that flag unchanged, so software can never set a flag.
- R4: When irqAck is high while irqPending is high, the flag of the slot given by irqVector in that same cycle is cleared, and the global disable flag becomes 1 after that clock edge.
- R5: A pin extPin[k] raises a request on a rising edge when its polarity bit (address 2, bit k) is 0, and on a falling edge when that bit is 1. The request flag reads 1 after the third rising clock edge that follows the pin change. Pin 0 feeds slot 1, pin 1 feeds slot 11 and pin 2 feeds slot 10.
- R6: Slots are ranked by index, and index 0 has the highest priority. A pulse on evtPulse[i] sets flag i for every slot except 1 and 11, whose evtPulse bits are ignored.
- R7: Slot 10 is shared. When address 2 bit 3 is 0, pin 2 edges set the flag and evtPulse[10] is ignored. When that bit is 1, evtPulse[10] sets the flag and pin 2 is ignored. A pending flag is kept when the select bit changes.
- R8: Slot 4 is shared. When address 2 bit 4 is 0, evtPulse[4] sets the flag and spritePulse is ignored. When that bit is 1, spritePulse sets the flag and evtPulse[4] is ignored.
- R9: A brkReq pulse makes a break pending. The break wins with vector 14 only when no maskable slot is eligible, whatever the state of the disable flag. Acknowledging the break clears it.
- R10: An event that sets a flag in the same cycle as that flag is cleared by acknowledge or by software leaves the flag set.
- R11: Address 3 bit 0 is the read/write global disable flag. An acknowledge in the same cycle as a software write of 0 to it leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtPulse | input | 14 | Internal event pulses, one per slot |
| spritePulse | input | 1 | Alternate event for shared slot 4 |
| extPin | input | 3 | Asynchronous external request pins |
| brkReq | input | 1 | Software-break request pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr (combinational) |
| irqPending | output | 1 | An interrupt is waiting to be taken |
| irqVector | output | 4 | Winning vector index (0..13 maskable, 14 break) |
| irqAck | input | 1 | CPU accepts the presented vector |

## Verification
The collision of interest is an acknowledge clearing a slot's flag in the same cycle as a new event for that very slot. A second such collision is a software clear meeting a new event. Both are provoked by raising irqAck, or a write of zero to the flag register, together with the matching evtPulse bit. The flag is then read back, and it must still be set. The acknowledge is also made to land on a cycle where software writes 0 to the disable flag, and the disable flag must read 1 afterwards.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_SLOTS   = 14;
  localparam int NUM_EXT     = 3;
  localparam int SYNC_STAGES = 2;
  localparam int REG_W       = 16;
  localparam int ADDR_W      = 2;
  localparam int CTL_W       = 5;
  localparam int VEC_W       = $clog2(NUM_SLOTS + 1);
  localparam logic [VEC_W-1:0] BRK_IDX = VEC_W'(NUM_SLOTS);

  localparam int SLOT_PIN0  = 1;
  localparam int SLOT_PAIRA = 4;
  localparam int SLOT_PAIRB = 10;
  localparam int SLOT_PIN1  = 11;

  localparam int CTL_SEL_B = 3;
  localparam int CTL_SEL_A = 4;

  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] A_ENAB  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_DIS   = 2'd3;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] clrMask;
    logic                 clrBrk;
    logic                 setDis;
  } irqStrobe_t;
endpackage

// File: rtl/vec_irq_edge.sv
module vec_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic fallMode,
  output logic edgeHit
);
  logic [STAGES-1:0] syncReg;
  logic              prevLvl;
  logic              curLvl;

  assign curLvl = syncReg[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncReg <= {syncReg[STAGES-2:0], pin};
      prevLvl <= curLvl;
    end
  end

  assign edgeHit = fallMode ? (prevLvl & ~curLvl) : (~prevLvl & curLvl);
endmodule

// File: rtl/vec_irq_dp.sv
module vec_irq_dp
  import vec_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] evtPulse,
  input  logic                 spritePulse,
  input  logic [NUM_EXT-1:0]   extPin,
  input  logic                 brkReq,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  irqStrobe_t           strobe,
  output logic [REG_W-1:0]     regRdData,
  output logic [NUM_SLOTS-1:0] reqFlags,
  output logic [NUM_SLOTS-1:0] enFlags,
  output logic                 disFlag,
  output logic                 brkPend,
  output logic [NUM_SLOTS-1:0] evtSet
);
  logic [CTL_W-1:0]     ctrlReg;
  logic [NUM_EXT-1:0]   extEdge;
  logic [NUM_SLOTS-1:0] swClr;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    vec_irq_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rstN    (rstN),
      .pin     (extPin[k]),
      .fallMode(ctrlReg[k]),
      .edgeHit (extEdge[k])
    );
  end

  always_comb begin
    evtSet             = evtPulse;
    evtSet[SLOT_PIN0]  = extEdge[0];
    evtSet[SLOT_PIN1]  = extEdge[1];
    evtSet[SLOT_PAIRB] = ctrlReg[CTL_SEL_B] ? evtPulse[SLOT_PAIRB] : extEdge[2];
    evtSet[SLOT_PAIRA] = ctrlReg[CTL_SEL_A] ? spritePulse : evtPulse[SLOT_PAIRA];
  end

  assign swClr = (regWrEn && regAddr == A_FLAGS) ? ~regWrData[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqFlags <= '0;
      enFlags  <= '0;
      ctrlReg  <= '0;
      disFlag  <= 1'b1;
      brkPend  <= 1'b0;
    end else begin
      reqFlags <= (reqFlags & ~swClr & ~strobe.clrMask) | evtSet;
      brkPend  <= (brkPend & ~strobe.clrBrk) | brkReq;
      if (regWrEn && regAddr == A_ENAB) enFlags <= regWrData[NUM_SLOTS-1:0];
      if (regWrEn && regAddr == A_CTRL) ctrlReg <= regWrData[CTL_W-1:0];
      if (strobe.setDis)                          disFlag <= 1'b1;
      else if (regWrEn && regAddr == A_DIS)       disFlag <= regWrData[0];
    end
  end

  always_comb begin
    unique case (regAddr)
      A_FLAGS: regRdData = REG_W'(reqFlags);
      A_ENAB:  regRdData = REG_W'(enFlags);
      A_CTRL:  regRdData = REG_W'(ctrlReg);
      default: regRdData = REG_W'(disFlag);
    endcase
  end
endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb
  import vec_irq_pkg::*;
(
  input  logic [NUM_SLOTS-1:0] reqFlags,
  input  logic [NUM_SLOTS-1:0] enFlags,
  input  logic                 disFlag,
  input  logic                 brkPend,
  input  logic                 irqAck,
  output logic                 irqPending,
  output logic [VEC_W-1:0]     irqVector,
  output irqStrobe_t           strobe
);
  logic [NUM_SLOTS-1:0] elig;
  logic [NUM_SLOTS-1:0] winMask;
  logic                 anyElig;
  logic                 take;

  assign elig    = reqFlags & enFlags & {NUM_SLOTS{~disFlag}};
  assign anyElig = |elig;

  always_comb begin
    irqVector = BRK_IDX;
    winMask   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        irqVector = VEC_W'(i);
        winMask   = NUM_SLOTS'(1) << i;
      end
    end
  end

  assign irqPending = anyElig | brkPend;
  assign take       = irqAck & irqPending;

  always_comb begin
    strobe.clrMask = take ? winMask : '0;
    strobe.clrBrk  = take & ~anyElig;
    strobe.setDis  = take;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] evtPulse,
  input  logic                 spritePulse,
  input  logic [NUM_EXT-1:0]   extPin,
  input  logic                 brkReq,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqPending,
  output logic [VEC_W-1:0]     irqVector,
  input  logic                 irqAck
);
  irqStrobe_t           strobe;
  logic [NUM_SLOTS-1:0] reqFlags;
  logic [NUM_SLOTS-1:0] enFlags;
  logic [NUM_SLOTS-1:0] evtSet;
  logic                 disFlag;
  logic                 brkPend;

  vec_irq_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .evtPulse   (evtPulse),
    .spritePulse(spritePulse),
    .extPin     (extPin),
    .brkReq     (brkReq),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strobe     (strobe),
    .regRdData  (regRdData),
    .reqFlags   (reqFlags),
    .enFlags    (enFlags),
    .disFlag    (disFlag),
    .brkPend    (brkPend),
    .evtSet     (evtSet)
  );

  vec_irq_arb u_arb (
    .reqFlags  (reqFlags),
    .enFlags   (enFlags),
    .disFlag   (disFlag),
    .brkPend   (brkPend),
    .irqAck    (irqAck),
    .irqPending(irqPending),
    .irqVector (irqVector),
    .strobe    (strobe)
  );
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk
  import vec_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 irqAck,
  input logic                 irqPending,
  input logic [VEC_W-1:0]     irqVector,
  input logic [NUM_SLOTS-1:0] reqFlags,
  input logic [NUM_SLOTS-1:0] enFlags,
  input logic                 disFlag,
  input logic                 brkPend,
  input logic [NUM_SLOTS-1:0] evtSet,
  input logic [NUM_SLOTS-1:0] clrMask
);
  assert_take_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && irqVector != BRK_IDX) |->
      (!disFlag && reqFlags[irqVector] && enFlags[irqVector]));

  assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((reqFlags & ~$past(reqFlags) & ~$past(evtSet)) == '0));

  assert_ack_sets_dis_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqPending) |=> disFlag);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqPending && irqVector != BRK_IDX && !evtSet[irqVector]) |=>
      !reqFlags[$past(irqVector)]);

  assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrMask));

  assert_brk_lowest_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && irqVector == BRK_IDX) |->
      (brkPend && (disFlag || (reqFlags & enFlags) == '0)));
endmodule

bind vec_irq_ctrl vec_irq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqAck    (irqAck),
  .irqPending(irqPending),
  .irqVector (irqVector),
  .reqFlags  (reqFlags),
  .enFlags   (enFlags),
  .disFlag   (disFlag),
  .brkPend   (brkPend),
  .evtSet    (evtSet),
  .clrMask   (strobe.clrMask)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] evtPulse = '0;
  logic        spritePulse = 1'b0;
  logic [2:0]  extPin = '0;
  logic        brkReq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqPending;
  logic [3:0]  irqVector;
  logic        irqAck = 1'b0;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .spritePulse(spritePulse),
    .extPin(extPin), .brkReq(brkReq), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqPending(irqPending),
    .irqVector(irqVector), .irqAck(irqAck)
  );

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      testCnt++;
      if (it.isIrq) begin
        if (irqPending !== it.exp[4] ||
            (it.exp[4] && irqVector !== it.exp[3:0])) begin
          failCnt++;
          $display("FAIL %s: pending=%0b vector=%0d expected pending=%0b vector=%0d",
                   it.tag, irqPending, irqVector, it.exp[4], it.exp[3:0]);
        end
      end else if (regRdData !== it.exp) begin
        failCnt++;
        $display("FAIL %s: read %h expected %h", it.tag, regRdData, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic expReg(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    regAddr = a;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    #1;
  endtask

  task automatic expIrq(input bit p, input int v, input string tag);
    item_t it;
    it.isIrq = 1'b1; it.exp = {11'd0, p, 4'(v)}; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    #1;
  endtask

  task automatic pulse(input int i);
    evtPulse[i] = 1'b1;
    tick();
    evtPulse = '0;
  endtask

  task automatic ack();
    irqAck = 1'b1;
    tick();
    irqAck = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int order [11] = '{0, 2, 3, 4, 5, 6, 7, 8, 9, 12, 13};
    tick(3);
    rstN = 1'b1;
    tick();

    // R1 reset state
    expReg(2'd0, 16'h0000, "R1 flags");
    expReg(2'd1, 16'h0000, "R1 enables");
    expReg(2'd2, 16'h0000, "R1 control");
    expReg(2'd3, 16'h0001, "R1 disable");
    expIrq(0, 0, "R1 pending");

    // R2 gating
    pulse(9);
    expReg(2'd0, 16'h0200, "R2 flag set");
    expIrq(0, 0, "R2 masked by enable");
    wr(2'd1, 16'h3FFF);
    expIrq(0, 0, "R2 masked by disable");
    wr(2'd3, 16'h0000);
    expIrq(1, 9, "R2 taken");

    // R4 acknowledge with priority
    pulse(2);
    expIrq(1, 2, "R4 winner before ack");
    ack();
    expReg(2'd0, 16'h0200, "R4 winner cleared");
    expReg(2'd3, 16'h0001, "R4 disable set");
    expIrq(0, 0, "R4 masked after ack");

    // R3 software clear only
    pulse(5);
    wr(2'd0, 16'h3FFF);
    expReg(2'd0, 16'h0220, "R3 write ones no effect");
    wr(2'd0, 16'h3FDF);
    expReg(2'd0, 16'h0200, "R3 clear one bit");
    wr(2'd0, 16'h0000);
    expReg(2'd0, 16'h0000, "R3 clear all");

    // R9 break ignores disable
    brkReq = 1'b1; tick(); brkReq = 1'b0;
    expIrq(1, 14, "R9 break while disabled");
    ack();
    expIrq(0, 0, "R9 break cleared");

    // R5 polarity and latency on pin 0
    extPin[0] = 1'b1;
    tick(2);
    expReg(2'd0, 16'h0000, "R5 not yet after two edges");
    tick();
    expReg(2'd0, 16'h0002, "R5 rising sets after three edges");
    wr(2'd0, 16'h0000);
    extPin[0] = 1'b0;
    tick(4);
    expReg(2'd0, 16'h0000, "R5 falling ignored in rise mode");
    wr(2'd2, 16'h0001);
    extPin[0] = 1'b1;
    tick(4);
    expReg(2'd0, 16'h0000, "R5 rising ignored in fall mode");
    extPin[0] = 1'b0;
    tick(4);
    expReg(2'd0, 16'h0002, "R5 falling sets in fall mode");
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    extPin[1] = 1'b1;
    tick(4);
    expReg(2'd0, 16'h0800, "R5 pin1 feeds slot 11");
    wr(2'd0, 16'h0000);

    // R7 shared slot 10
    pulse(10);
    expReg(2'd0, 16'h0000, "R7 adc ignored when pin selected");
    extPin[2] = 1'b1;
    tick(4);
    expReg(2'd0, 16'h0400, "R7 pin2 sets slot 10");
    wr(2'd2, 16'h0008);
    expReg(2'd0, 16'h0400, "R7 pending kept on select change");
    wr(2'd0, 16'h0000);
    extPin[2] = 1'b0;
    tick(4);
    extPin[2] = 1'b1;
    tick(4);
    expReg(2'd0, 16'h0000, "R7 pin2 ignored when adc selected");
    pulse(10);
    expReg(2'd0, 16'h0400, "R7 adc sets slot 10");
    extPin[2] = 1'b0;
    wr(2'd0, 16'h0000);

    // R8 shared slot 4
    wr(2'd2, 16'h0000);
    spritePulse = 1'b1; tick(); spritePulse = 1'b0;
    expReg(2'd0, 16'h0000, "R8 sprite ignored");
    pulse(4);
    expReg(2'd0, 16'h0010, "R8 timer event sets");
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0010);
    pulse(4);
    expReg(2'd0, 16'h0000, "R8 timer event ignored");
    spritePulse = 1'b1; tick(); spritePulse = 1'b0;
    expReg(2'd0, 16'h0010, "R8 sprite sets");
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);

    // R6 full priority walk, then break last (R9)
    evtPulse = 14'h3FFF; brkReq = 1'b1;
    tick();
    evtPulse = '0; brkReq = 1'b0;
    expReg(2'd0, 16'h33FD, "R6 pins-only slots ignore evtPulse");
    for (int k = 0; k < 11; k++) begin
      wr(2'd3, 16'h0000);
      expIrq(1, order[k], "R6 priority order");
      ack();
    end
    wr(2'd3, 16'h0000);
    expIrq(1, 14, "R9 break lowest");
    ack();
    expIrq(0, 0, "R9 all served");

    // R10 set beats clear
    wr(2'd3, 16'h0000);
    pulse(7);
    expIrq(1, 7, "R10 setup");
    irqAck = 1'b1; evtPulse[7] = 1'b1;
    tick();
    irqAck = 1'b0; evtPulse = '0;
    expReg(2'd0, 16'h0080, "R10 event beats ack clear");
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 16'h0000; evtPulse[7] = 1'b1;
    tick();
    regWrEn = 1'b0; evtPulse = '0;
    expReg(2'd0, 16'h0080, "R10 event beats software clear");

    // R11 ack beats software write of disable
    wr(2'd3, 16'h0000);
    expIrq(1, 7, "R11 setup");
    irqAck = 1'b1; regWrEn = 1'b1; regAddr = 2'd3; regWrData = 16'h0000;
    tick();
    irqAck = 1'b0; regWrEn = 1'b0;
    expReg(2'd3, 16'h0001, "R11 ack wins over write");
    expReg(2'd0, 16'h0000, "R4 flag cleared on collision ack");

    // R2 enable selects lower slot
    wr(2'd1, 16'h0008);
    pulse(0);
    pulse(3);
    wr(2'd3, 16'h0000);
    expIrq(1, 3, "R2 disabled high slot skipped");

    done = 1'b1;
    tick();
    summary();
    $finish;
  end
endmodule